// File: doc/BRIEF.md
# UART Interrupt Status Aggregator

This block collects the interrupt causes of a serial port into one raw status word and drives a single interrupt request toward the system interrupt controller. Four of the causes are plain event pulses from the receive and error logic: overrun, break, parity and framing. A fifth pulse, receive time-out, arrives from an external counter. The remaining two causes, receive and transmit, are derived inside the block. It compares the FIFO fill levels against programmed trigger levels, and an end-of-transmission mode can replace the trigger level for the transmit cause.

Software sees the block through a small register port. It reads the raw status and the masked status, and it writes a mask register. It clears status through a write-one-to-clear register. The receive and transmit causes set on a transition of a fill-level condition, not on the level itself. So a cleared bit stays cleared until the FIFO has left the triggering region and entered it again.

Top module: `uart_irq_agg`

## Requirements
- R1: A synchronous reset clears every raw status bit and the mask register. After reset the interrupt output is low and every register reads zero.
- R2: Each event pulse sets its raw bit on the next clock edge, and the bit then holds until it is cleared. The bit positions are: overrun 6, break 5, parity 4, framing 3, receive time-out 2.
- R3: The register map is as follows. Address 0 is the mask, readable and writable on bits 6:0. Address 1 reads the raw status. Address 2 reads raw AND mask. Address 3 is the clear register and reads zero. Writes to addresses 1 and 2 have no effect.
- R4: The interrupt output is the OR of all bits of raw AND mask. With the mask at zero the output is low whatever the raw status is.
- R5: Writing 1 to a bit of the clear register clears that raw bit on the next edge, and writing 0 leaves it unchanged. When an event pulse and a clear of the same bit fall in the same cycle, the bit stays set.
- R6: The trigger select encodes 0, 1, 2, 3 and 4 as 2, 4, 8, 12 and 14 entries of a 16-entry FIFO. Codes 5 to 7 mean 8 entries.
- R7: With FIFOs enabled, the receive bit (bit 0) sets in the cycle the receive fill moves from below the trigger level to at or above it. It clears when the fill drops below that level. A write-one-to-clear made while the fill stays at or above the level is not undone.
- R8: With FIFOs disabled, the receive trigger level is one entry. The bit sets when the fill goes from zero to nonzero and clears when the fill returns to zero.
- R9: With FIFOs enabled and end-of-transmission mode off, the transmit bit (bit 1) sets only when the transmit fill moves from above the trigger level to at or below it. It clears when the fill rises above the level. It does not set after reset, nor while the fill stays at or below the level after a clear.
- R10: With FIFOs disabled and end-of-transmission mode off, the transmit bit sets when the transmit fill goes from nonzero to zero and clears when the fill becomes nonzero.
- R11: In end-of-transmission mode, the transmit bit sets when "serializer idle and transmit fill zero" becomes true and clears when it becomes false. Threshold crossings are then ignored.
- R12: The receive time-out bit also clears whenever the receive fill is zero, unless a time-out pulse arrives in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_overrun | input | 1 | Overrun event pulse |
| ev_break | input | 1 | Break event pulse |
| ev_parity | input | 1 | Parity error pulse |
| ev_framing | input | 1 | Framing error pulse |
| ev_rx_timeout | input | 1 | Receive time-out pulse |
| rx_fill | input | 5 | Receive FIFO fill level, 0 to 16 |
| tx_fill | input | 5 | Transmit FIFO fill level, 0 to 16 |
| rx_sel | input | 3 | Receive trigger select |
| tx_sel | input | 3 | Transmit trigger select |
| fifo_en | input | 1 | FIFOs enabled (0: single-entry mode) |
| eot_mode | input | 1 | End-of-transmission mode for the transmit cause |
| ser_idle | input | 1 | Serializer has shifted out its last bit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 7 | Register write data |
| reg_rdata | output | 7 | Register read data (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest state to reach is a transmit bit that has been cleared by software while the fill sits at or below the trigger level. Level sampling alone would re-set that bit at once. The bench gets there in two steps for every trigger select. First it parks the transmit fill above the level and clears the status. Then it walks the fill down to zero and back up one entry per cycle. Each step is compared against an arithmetically derived threshold. The bench also clears the bit at zero fill and walks up to the level again to show that it stays clear. Receive sweeps use the same method from the opposite side, and a clear colliding with an overrun pulse covers the same-cycle priority.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NSRC = 7;

    typedef enum int unsigned {
        SRC_RX = 0,
        SRC_TX = 1,
        SRC_RT = 2,
        SRC_FE = 3,
        SRC_PE = 4,
        SRC_BE = 5,
        SRC_OE = 6
    } src_e;

    typedef enum logic [1:0] {
        ADDR_MASK = 2'd0,
        ADDR_RAW  = 2'd1,
        ADDR_MIS  = 2'd2,
        ADDR_CLR  = 2'd3
    } addr_e;

    typedef struct packed {
        logic set;
        logic clr;
    } lvl_evt_t;

    // Threshold in entries: select picks a number of eighths of the depth.
    function automatic int unsigned level_thr(input logic [2:0] sel, input int unsigned depth);
        int unsigned eighths;
        case (sel)
            3'd0:    eighths = 1;
            3'd1:    eighths = 2;
            3'd2:    eighths = 4;
            3'd3:    eighths = 6;
            3'd4:    eighths = 7;
            default: eighths = 4;
        endcase
        return (depth * eighths) / 8;
    endfunction

endpackage

// File: rtl/uart_irq_edge.sv
module uart_irq_edge
    import uart_irq_pkg::*;
#(
    parameter logic RST_PREV = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cond,
    output lvl_evt_t evt
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_PREV;
        else     prev_q <= cond;
    end

    always_comb begin
        evt.set = cond & ~prev_q;
        evt.clr = ~cond;
    end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] hw_set,
    input  logic [N-1:0] hw_clr,
    input  logic [N-1:0] sw_clr,
    output logic [N-1:0] raw
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)                        bit_q <= 1'b0;
            else if (hw_set[i])             bit_q <= 1'b1;
            else if (hw_clr[i] || sw_clr[i]) bit_q <= 1'b0;
        end
        assign raw[i] = bit_q;
    end
endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
    import uart_irq_pkg::*;
#(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         reg_wr,
    input  logic [1:0]   reg_addr,
    input  logic [N-1:0] reg_wdata,
    input  logic [N-1:0] raw,
    output logic [N-1:0] mask,
    output logic [N-1:0] sw_clr,
    output logic [N-1:0] reg_rdata
);
    logic [N-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst)                                   mask_q <= '0;
        else if (reg_wr && reg_addr == ADDR_MASK)  mask_q <= reg_wdata;
    end

    assign mask   = mask_q;
    assign sw_clr = (reg_wr && reg_addr == ADDR_CLR) ? reg_wdata : '0;

    always_comb begin
        case (reg_addr)
            ADDR_MASK: reg_rdata = mask_q;
            ADDR_RAW:  reg_rdata = raw;
            ADDR_MIS:  reg_rdata = raw & mask_q;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_irq_agg.sv
module uart_irq_agg
    import uart_irq_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_overrun,
    input  logic              ev_break,
    input  logic              ev_parity,
    input  logic              ev_framing,
    input  logic              ev_rx_timeout,
    input  logic [FILL_W-1:0] rx_fill,
    input  logic [FILL_W-1:0] tx_fill,
    input  logic [2:0]        rx_sel,
    input  logic [2:0]        tx_sel,
    input  logic              fifo_en,
    input  logic              eot_mode,
    input  logic              ser_idle,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [NSRC-1:0]   reg_wdata,
    output logic [NSRC-1:0]   reg_rdata,
    output logic              irq
);
    logic [FILL_W-1:0] rx_thr, tx_thr;
    logic              rx_cond, tx_cond;
    lvl_evt_t          rx_evt, tx_evt;
    logic [NSRC-1:0]   hw_set, hw_clr, sw_clr, raw_q, mask_q;

    always_comb begin
        rx_thr  = fifo_en ? FILL_W'(level_thr(rx_sel, DEPTH)) : FILL_W'(1);
        tx_thr  = FILL_W'(level_thr(tx_sel, DEPTH));
        rx_cond = (rx_fill >= rx_thr);
        if (eot_mode)     tx_cond = ser_idle && (tx_fill == '0);
        else if (fifo_en) tx_cond = (tx_fill <= tx_thr);
        else              tx_cond = (tx_fill == '0);
    end

    uart_irq_edge #(.RST_PREV(1'b0)) rx_edge_i (
        .clk(clk), .rst(rst), .cond(rx_cond), .evt(rx_evt)
    );

    uart_irq_edge #(.RST_PREV(1'b1)) tx_edge_i (
        .clk(clk), .rst(rst), .cond(tx_cond), .evt(tx_evt)
    );

    always_comb begin
        hw_set         = '0;
        hw_clr         = '0;
        hw_set[SRC_RX] = rx_evt.set;
        hw_clr[SRC_RX] = rx_evt.clr;
        hw_set[SRC_TX] = tx_evt.set;
        hw_clr[SRC_TX] = tx_evt.clr;
        hw_set[SRC_RT] = ev_rx_timeout;
        hw_clr[SRC_RT] = (rx_fill == '0);
        hw_set[SRC_FE] = ev_framing;
        hw_set[SRC_PE] = ev_parity;
        hw_set[SRC_BE] = ev_break;
        hw_set[SRC_OE] = ev_overrun;
    end

    uart_irq_status #(.N(NSRC)) status_i (
        .clk(clk), .rst(rst), .hw_set(hw_set), .hw_clr(hw_clr),
        .sw_clr(sw_clr), .raw(raw_q)
    );

    uart_irq_regs #(.N(NSRC)) regs_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .raw(raw_q), .mask(mask_q),
        .sw_clr(sw_clr), .reg_rdata(reg_rdata)
    );

    assign irq = |(raw_q & mask_q);
endmodule

// File: rtl/uart_irq_agg_chk.sv
module uart_irq_agg_chk
    import uart_irq_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int FILL_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              ev_overrun,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [NSRC-1:0]   reg_wdata,
    input logic [FILL_W-1:0] rx_fill,
    input logic [FILL_W-1:0] tx_fill,
    input logic [2:0]        rx_sel,
    input logic [2:0]        tx_sel,
    input logic              fifo_en,
    input logic              eot_mode,
    input logic              irq,
    input logic [NSRC-1:0]   raw,
    input logic [NSRC-1:0]   mask
);
    logic [FILL_W-1:0] c_rx_thr, c_tx_thr;
    assign c_rx_thr = FILL_W'(level_thr(rx_sel, DEPTH));
    assign c_tx_thr = FILL_W'(level_thr(tx_sel, DEPTH));

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (raw == '0 && mask == '0)); // R1
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst) ev_overrun |=> raw[SRC_OE]); // R2
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst) irq |-> (mask != '0)); // R4
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_CLR && reg_wdata[SRC_OE] && !ev_overrun) |=> !raw[SRC_OE]); // R5
    AST_RX_BELOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && rx_fill < c_rx_thr) |=> !raw[SRC_RX]); // R7
    AST_TX_ABOVE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && !eot_mode && tx_fill > c_tx_thr) |=> !raw[SRC_TX]); // R9
endmodule

bind uart_irq_agg uart_irq_agg_chk #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst(rst), .ev_overrun(ev_overrun), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rx_fill(rx_fill),
    .tx_fill(tx_fill), .rx_sel(rx_sel), .tx_sel(tx_sel), .fifo_en(fifo_en),
    .eot_mode(eot_mode), .irq(irq), .raw(raw_q), .mask(mask_q)
);

// File: tb/uart_irq_agg_tb_top.sv
`timescale 1ns/1ps
module uart_irq_agg_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_overrun = 0, ev_break = 0, ev_parity = 0, ev_framing = 0, ev_rx_timeout = 0;
    logic [4:0] rx_fill = 0, tx_fill = 0;
    logic [2:0] rx_sel = 0, tx_sel = 0;
    logic       fifo_en = 0, eot_mode = 0, ser_idle = 0;
    logic       reg_wr = 0;
    logic [1:0] reg_addr = 0;
    logic [6:0] reg_wdata = 0;
    logic [6:0] reg_rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    uart_irq_agg dut_i (
        .clk(clk), .rst(rst), .ev_overrun(ev_overrun), .ev_break(ev_break),
        .ev_parity(ev_parity), .ev_framing(ev_framing), .ev_rx_timeout(ev_rx_timeout),
        .rx_fill(rx_fill), .tx_fill(tx_fill), .rx_sel(rx_sel), .tx_sel(tx_sel),
        .fifo_en(fifo_en), .eot_mode(eot_mode), .ser_idle(ser_idle),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic int exp_thr(input int sel);
        int e;
        e = (sel == 0) ? 1 : (sel == 1) ? 2 : (sel == 2) ? 4 : (sel == 3) ? 6 : (sel == 4) ? 7 : 4;
        return 16 * e / 8;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [6:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [6:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_bit(input string req, input int b, input logic exp);
        logic [6:0] d;
        rd(2'd1, d);
        chk(req, 32'(d[b]), 32'(exp));
    endtask

    initial begin
        #(5.0 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [6:0] d;
        tick(); tick(); tick();
        rst = 1'b0;
        tick();
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk("R1 reg after reset", 32'(d), 0);
        end
        chk("R1 irq after reset", 32'(irq), 0);

        // R3: register map
        wr(2'd0, 7'h55);
        rd(2'd0, d); chk("R3 mask readback", 32'(d), 32'h55);
        wr(2'd1, 7'h7f);
        rd(2'd1, d); chk("R3 raw write ignored", 32'(d), 0);
        wr(2'd2, 7'h0f);
        rd(2'd0, d); chk("R3 masked write ignored", 32'(d), 32'h55);
        rd(2'd3, d); chk("R3 clear reads zero", 32'(d), 0);

        // R2, R4: events
        wr(2'd0, 7'h7f);
        ev_framing = 1; tick(); ev_framing = 0;
        rd(2'd1, d); chk("R2 framing bit3", 32'(d), 32'h08);
        chk("R4 irq on framing", 32'(irq), 1);
        ev_parity = 1; tick(); ev_parity = 0;
        ev_break = 1;  tick(); ev_break = 0;
        ev_overrun = 1; tick(); ev_overrun = 0;
        tick();
        rd(2'd1, d); chk("R2 all errors held", 32'(d), 32'h78);
        wr(2'd0, 7'h00);
        chk("R4 irq masked off", 32'(irq), 0);
        rd(2'd2, d); chk("R3 masked status zero", 32'(d), 0);
        wr(2'd0, 7'h20);
        chk("R4 irq single mask bit", 32'(irq), 1);
        rd(2'd2, d); chk("R3 masked status", 32'(d), 32'h20);

        // R5: write-one-to-clear
        wr(2'd3, 7'h00);
        rd(2'd1, d); chk("R5 zero write no effect", 32'(d), 32'h78);
        ev_overrun = 1;
        wr(2'd3, 7'h40);
        ev_overrun = 0;
        rd(2'd1, d); chk("R5 event beats clear", 32'(d), 32'h78);
        wr(2'd3, 7'h30);
        rd(2'd1, d); chk("R5 partial clear", 32'(d), 32'h48);
        wr(2'd3, 7'h7f);
        rd(2'd1, d); chk("R5 clear all", 32'(d), 0);
        chk("R4 irq low after clear", 32'(irq), 0);

        // R12: time-out clears on empty receive FIFO
        fifo_en = 1; rx_sel = 3'd2;
        ev_rx_timeout = 1; tick(); ev_rx_timeout = 0;
        chk_bit("R12 timeout sets", 2, 1'b1);
        tick();
        chk_bit("R12 timeout cleared by empty fifo", 2, 1'b0);
        rx_fill = 5'd3; tick();
        ev_rx_timeout = 1; tick(); ev_rx_timeout = 0;
        tick();
        chk_bit("R12 timeout held with data", 2, 1'b1);
        rx_fill = 5'd0; tick();
        chk_bit("R12 timeout cleared on drain", 2, 1'b0);

        // R6, R7: receive sweeps per select
        for (int s = 0; s < 8; s++) begin
            int t;
            t = exp_thr(s);
            rx_sel = 3'(s); fifo_en = 1; rx_fill = 0; tick();
            wr(2'd3, 7'h7f);
            for (int f = 1; f <= 16; f++) begin
                rx_fill = 5'(f); tick();
                chk_bit($sformatf("R6 R7 rx up sel=%0d fill=%0d", s, f), 0, f >= t);
            end
            wr(2'd3, 7'h01);
            tick();
            chk_bit("R7 rx clear sticks at full", 0, 1'b0);
            for (int f = 15; f >= 0; f--) begin
                rx_fill = 5'(f); tick();
                chk_bit($sformatf("R7 rx down sel=%0d fill=%0d", s, f), 0, 1'b0);
            end
            rx_fill = 5'(t); tick();
            chk_bit("R7 rx re-arms", 0, 1'b1);
            rx_fill = 0; tick();
        end

        // R8: receive single-entry mode
        fifo_en = 0; rx_sel = 3'd4; rx_fill = 0; tick();
        rx_fill = 1; tick();
        chk_bit("R8 rx sets on one entry", 0, 1'b1);
        wr(2'd3, 7'h01);
        chk_bit("R8 rx clear", 0, 1'b0);
        rx_fill = 0; tick();
        rx_fill = 1; tick();
        chk_bit("R8 rx sets again", 0, 1'b1);
        rx_fill = 0; tick();
        chk_bit("R8 rx clears on read", 0, 1'b0);
        wr(2'd3, 7'h7f);

        // R6, R9: transmit sweeps per select
        fifo_en = 1;
        for (int s = 0; s < 8; s++) begin
            int t;
            t = exp_thr(s);
            tx_sel = 3'(s); tx_fill = 16; tick();
            wr(2'd3, 7'h02);
            for (int f = 15; f >= 0; f--) begin
                tx_fill = 5'(f); tick();
                chk_bit($sformatf("R6 R9 tx down sel=%0d fill=%0d", s, f), 1, f <= t);
            end
            for (int f = 1; f <= 16; f++) begin
                tx_fill = 5'(f); tick();
                chk_bit($sformatf("R9 tx up sel=%0d fill=%0d", s, f), 1, f <= t);
            end
            tx_fill = 0; tick();
            wr(2'd3, 7'h02);
            for (int f = 0; f <= t; f++) begin
                tx_fill = 5'(f); tick();
                chk_bit($sformatf("R9 tx no reset below sel=%0d fill=%0d", s, f), 1, 1'b0);
            end
        end

        // R10: transmit single-entry mode
        fifo_en = 0; tx_fill = 1; tick();
        wr(2'd3, 7'h02);
        chk_bit("R10 tx clear while full", 1, 1'b0);
        tx_fill = 0; tick();
        chk_bit("R10 tx sets on empty", 1, 1'b1);
        tx_fill = 1; tick();
        chk_bit("R10 tx clears on write", 1, 1'b0);

        // R11: end-of-transmission mode
        fifo_en = 1; eot_mode = 1; tx_sel = 3'd2; ser_idle = 0; tx_fill = 16; tick();
        wr(2'd3, 7'h02);
        for (int f = 15; f >= 0; f--) begin
            tx_fill = 5'(f); tick();
            chk_bit($sformatf("R11 no threshold set fill=%0d", f), 1, 1'b0);
        end
        ser_idle = 1; tick();
        chk_bit("R11 sets on serializer idle", 1, 1'b1);
        tx_fill = 1; ser_idle = 0; tick();
        chk_bit("R11 clears on new data", 1, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule